// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator with Shared Enable/Pending Word

This block watches a small group of asynchronous level signals and converts every transition on them into a latched interrupt request. Each watched line feeds two sources: one for a low-to-high change and one for a high-to-low change. The two sources sit next to each other in the source numbering, with the rising one at the even index. Once a source has been latched pending, it stays pending until software clears it. This holds whether or not the source is enabled.

Software sees the whole block through one 32-bit word at a single address. The lower half carries the per-source enables. The upper half carries the pending flags, and each flag sits exactly sixteen bit positions above its enable. Only a window of bits is implemented: it starts at parameter `SRC_BASE` and is `2*NUM_LINES` bits wide. A write always replaces the enable field. In the pending field, a 1 clears the flag and a 0 has no effect. Software can therefore acknowledge one source by writing back the current enables plus that single clear bit. A single registered output tells a parent controller that at least one enabled source is pending.

Top module: `sic_edge_irq`

## Requirements
- R1: After a synchronous active-high reset the read word is 0x00000000 and `irq_o` is low.
- R2: Each write loads bits 15:0 into the enables, but only inside the window from `SRC_BASE` to `SRC_BASE+2*NUM_LINES-1`. Enable bits outside the window read 0. With the defaults (base 0, three lines) the window is bits 5:0, so writing 0x0000FFFF reads back 0x0000003F.
- R3: The read word is {pending[15:0], enable[15:0]}. A source's pending flag sits at its enable position plus 16, and bits outside the window in both halves read 0.
- R4: Line k drives source `SRC_BASE+2k` on a low-to-high change and source `SRC_BASE+2k+1` on a high-to-low change. Each line passes through a two-flop synchroniser. The pending flag appears three clocks after the input changes.
- R5: A detected edge sets its pending flag even while the source's enable is 0.
- R6: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged. Pending bits also hold when no write occurs.
- R7: `irq_o` is a register. In any cycle it equals, from the previous cycle, the OR over all sources of (pending AND enable).
- R8: If an edge and a write-1-to-clear reach the same pending bit in the same cycle, the bit ends up set.
- R9: Enabling a source that is already pending raises `irq_o` one clock after the write edge, and not at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_i | input | NUM_LINES | Asynchronous lines watched for transitions |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data: [31:16] clear mask, [15:0] enables |
| rd_data_o | output | 32 | Read data: [31:16] pending, [15:0] enables |
| irq_o | output | 1 | Summary interrupt to the parent controller |

## Verification
The bench lines up a line transition so that its edge lands in the same cycle as a write that clears the same bit. A design that let the clear win would lose that event, and the pending bit would read 0. The bench also writes clear masks that are zero and writes while sources are disabled. A design that treated zeros as a plain overwrite would drop pending flags, and one that gated latching on the enable would never record the edge. The bench checks `irq_o` on the exact cycles around an enable write, so an output that was combinational or one cycle too slow shows up at once. The falling sources are checked separately to catch rising and falling swapped within a pair.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    // Order of the two sources produced by one watched line.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    typedef struct packed {
        logic [HALF_W-1:0] pend;
        logic [HALF_W-1:0] en;
    } sic_word_t;

    // Mask of implemented source bits within one half of the word.
    function automatic logic [HALF_W-1:0] win_mask(input int base, input int count);
        logic [HALF_W-1:0] m;
        m = '0;
        for (int i = 0; i < HALF_W; i++) begin
            if (i >= base && i < base + count) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic int src_index(input int base, input int line, input edge_kind_e kind);
        return base + 2 * line + int'(kind);
    endfunction

endpackage

// File: rtl/sic_edge_detect.sv
module sic_edge_detect #(
    parameter int NUM_LINES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] line_i,
    output logic [NUM_LINES-1:0] rise_o,
    output logic [NUM_LINES-1:0] fall_o
);

    logic [NUM_LINES-1:0] meta_q;
    logic [NUM_LINES-1:0] sync_q;
    logic [NUM_LINES-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        assign rise_o[k] = sync_q[k] & ~last_q[k];
        assign fall_o[k] = ~sync_q[k] & last_q[k];

        // R4: a rising pulse is always followed by a stable-high delayed copy
        p_rise_then_high_r4: assert property (@(posedge clk) disable iff (rst)
            rise_o[k] |=> last_q[k]);
        p_fall_then_low_r4: assert property (@(posedge clk) disable iff (rst)
            fall_o[k] |=> !last_q[k]);
    end

endmodule

// File: rtl/sic_src_bits.sv
module sic_src_bits
    import sic_pkg::*;
#(
    parameter logic [HALF_W-1:0] MASK = 16'h003F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] set_vec_i,
    input  logic              wr_en_i,
    input  sic_word_t         wr_word_i,
    output sic_word_t         word_o
);

    sic_word_t word_q;
    sic_word_t word_d;

    always_comb begin
        word_d = word_q;
        if (wr_en_i) begin
            word_d.en   = wr_word_i.en & MASK;
            word_d.pend = word_q.pend & ~(wr_word_i.pend & MASK);
        end
        // New edges are applied last so they win over a same-cycle clear.
        word_d.pend = word_d.pend | (set_vec_i & MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign word_o = word_q;

    // R4 / R8: every detected edge leaves its pending bit set
    p_edge_sets_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_vec_i) & MASK & ~word_q.pend) == '0));
    // R6: without a write no pending bit drops
    p_hold_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> (($past(word_q.pend) & ~word_q.pend) == '0));
    // R6: zeros in the clear mask keep their pending bits
    p_zero_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (($past(word_q.pend) & ~$past(wr_word_i.pend) & ~word_q.pend) == '0));
    // R2: enables outside the window never become set
    p_window_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> ((word_q.en & ~MASK) == '0));

endmodule

// File: rtl/sic_irq_gen.sv
module sic_irq_gen
    import sic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sic_word_t word_i,
    output logic      irq_o
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(word_i.pend & word_i.en);
    end

    assign irq_o = irq_q;

    // R7: an enabled pending source raises the line one cycle later
    p_irq_raise_r7: assert property (@(posedge clk) disable iff (rst)
        (|(word_i.pend & word_i.en)) |=> irq_o);
    // R7: no enabled pending source drops the line one cycle later
    p_irq_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !(|(word_i.pend & word_i.en)) |=> !irq_o);

endmodule

// File: rtl/sic_edge_irq.sv
module sic_edge_irq
    import sic_pkg::*;
#(
    parameter int NUM_LINES = 3,
    parameter int SRC_BASE  = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic                 wr_en_i,
    input  logic [WORD_W-1:0]    wr_data_i,
    output logic [WORD_W-1:0]    rd_data_o,
    output logic                 irq_o
);

    localparam int                SRC_COUNT = 2 * NUM_LINES;
    localparam logic [HALF_W-1:0] SRC_MASK  = win_mask(SRC_BASE, SRC_COUNT);

    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] fall;
    logic [HALF_W-1:0]    set_vec;
    sic_word_t            wr_word;
    sic_word_t            cur_word;

    sic_edge_detect #(
        .NUM_LINES(NUM_LINES)
    ) u_edges (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    always_comb begin
        set_vec = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            set_vec[src_index(SRC_BASE, k, EDGE_RISE)] = rise[k];
            set_vec[src_index(SRC_BASE, k, EDGE_FALL)] = fall[k];
        end
    end

    assign wr_word = wr_data_i;

    sic_src_bits #(
        .MASK(SRC_MASK)
    ) u_bits (
        .clk       (clk),
        .rst       (rst),
        .set_vec_i (set_vec),
        .wr_en_i   (wr_en_i),
        .wr_word_i (wr_word),
        .word_o    (cur_word)
    );

    sic_irq_gen u_irq (
        .clk    (clk),
        .rst    (rst),
        .word_i (cur_word),
        .irq_o  (irq_o)
    );

    assign rd_data_o = cur_word;

    // R3: nothing outside the window is ever visible in either half
    p_unused_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o & ~{SRC_MASK, SRC_MASK}) == '0);

endmodule

// File: tb/sic_edge_irq_tb.sv
module sic_edge_irq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  line = 3'b000;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sic_edge_irq #(.NUM_LINES(3), .SRC_BASE(0)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .line_i    (line),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    // Fields: [68:66] lines, [65] write, [64:33] wdata, [32:1] expected word, [0] expected irq
    localparam logic [68:0] VEC [0:11] = '{
        {3'b000, 1'b1, 32'h0000FFFF, 32'h0000003F, 1'b0}, // R2 window
        {3'b001, 1'b0, 32'h0, 32'h0001003F, 1'b1},        // R4 rise line0, R7
        {3'b000, 1'b0, 32'h0, 32'h0003003F, 1'b1},        // R4 fall line0
        {3'b000, 1'b1, 32'h0001003F, 32'h0002003F, 1'b1}, // R6 clear one
        {3'b000, 1'b1, 32'h00000000, 32'h00020000, 1'b0}, // R6 zero keeps, R7
        {3'b100, 1'b0, 32'h0, 32'h00120000, 1'b0},        // R5 rise line2 disabled
        {3'b110, 1'b0, 32'h0, 32'h00160000, 1'b0},        // R4 rise line1
        {3'b110, 1'b1, 32'h00000004, 32'h00160004, 1'b1}, // R7
        {3'b110, 1'b1, 32'hFFFF0004, 32'h00000004, 1'b0}, // R6 clear all, R3
        {3'b010, 1'b0, 32'h0, 32'h00200004, 1'b0},        // R4 fall line2
        {3'b000, 1'b0, 32'h0, 32'h00280004, 1'b0},        // R4 fall line1
        {3'b000, 1'b1, 32'h00000008, 32'h00280008, 1'b1}  // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 32'h0;
    endtask

    initial begin
        settle(4);
        check("R1 word", rd_data, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rst = 1'b0;
        settle(1);
        check("R1 word after release", rd_data, 32'h0);

        for (int v = 0; v < 12; v++) begin
            line = VEC[v][68:66];
            if (VEC[v][65]) do_write(VEC[v][64:33]);
            else @(negedge clk);
            settle(5);
            check($sformatf("R7/vector %0d word", v), rd_data, VEC[v][32:1]);
            check($sformatf("R7/vector %0d irq", v), {31'h0, irq}, {31'h0, VEC[v][0]});
        end

        // R8: edge and clear of the same bit in the same cycle
        do_write(32'h003F0000);
        settle(5);
        check("R6 clear all", rd_data, 32'h0);
        line = 3'b001; settle(6);
        line = 3'b000; settle(6);
        check("R4 pair on line0", rd_data, 32'h00030000);
        line = 3'b001;
        settle(2);
        do_write(32'h00010000);
        settle(5);
        check("R8 set wins", rd_data, 32'h00030000);
        do_write(32'h00010000);
        settle(3);
        check("R6 clear without edge", rd_data, 32'h00020000);

        // R9: exact cycle of irq after enabling a pending source
        wr_en = 1'b1;
        wr_data = 32'h00000002;
        @(negedge clk);
        check("R9 enable stored", rd_data, 32'h00020002);
        check("R9 irq not yet", {31'h0, irq}, 32'h0);
        wr_en = 1'b0;
        wr_data = 32'h0;
        @(negedge clk);
        check("R9 irq next cycle", {31'h0, irq}, 32'h1);

        // R1: reset mid-run
        rst = 1'b1;
        settle(2);
        check("R1 reset word", rd_data, 32'h0);
        check("R1 reset irq", {31'h0, irq}, 32'h0);
        rst = 1'b0;
        settle(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule